// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between a write-through first-level data cache and a write-back second-level cache. The core hands it 64-bit stores, each with an eight-bit byte enable. The buffer keeps them in a small queue of entries. Each entry covers one aligned 16-byte line and has a byte-valid mask. The second-level cache takes one 16-byte write at most once every four cycles, so the buffer paces its drain port to that rate.

When combining is enabled, a store whose line matches a live entry is folded into that entry. It does not take a new entry. The enabled bytes overwrite the old ones and the masks are ORed. This lets two 64-bit halves of a line leave as a single downstream write. When combining is disabled, every store takes its own entry. Entries leave in the order they were allocated. Each write carries its mask, so a partly filled line updates only the bytes it holds. The entry at the head is frozen while it is offered on the drain port.

Top module: `stbuf_merge`

## Requirements
- R1: During and right after reset, `dr_valid` is 0 and `st_ready` is 1.
- R2: Stores arrive 8-byte aligned. A store with `st_addr[3]`=0 lands in data bits 63:0 and mask bits 7:0. One with `st_addr[3]`=1 lands in data bits 127:64 and mask bits 15:8. The drained address is the store address with bits 3:0 cleared, and the drained mask is never zero. When the drain side is idle and `dr_accept` is high, a lone store is written downstream at the clock edge right after the one that accepted it.
- R3: With `merge_en`=1, a store to the line of a live, unfrozen entry joins that entry. Two halves of one line leave as one write with mask 16'hFFFF.
- R4: When merged stores overlap, the bytes of the later store win, and the mask is the OR of both enables.
- R5: With `merge_en`=0, every store takes its own entry and causes its own downstream write, even when the lines are the same.
- R6: Entries drain in the order they were allocated.
- R7: Two drain handshakes (`dr_valid` and `dr_accept` both high) are at least 4 clock edges apart.
- R8: `st_ready` is 0 exactly when all 4 entries are live and the store has no merge target. The buffer never holds more than 4 entries.
- R9: The entry being offered on the drain port (`dr_valid`=1) takes no merges. A store to its line allocates a new entry.
- R10: Once `dr_valid` rises, it stays high with a stable address, data and mask until `dr_accept` is seen.
- R11: A store with all-zero byte enables is accepted and discarded. It causes no downstream write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| merge_en | input | 1 | 1: combine stores to the same line; 0: one entry per store |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 32 | Store byte address, 8-byte aligned |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte enables |
| dr_valid | output | 1 | A line write is offered downstream |
| dr_accept | input | 1 | Downstream takes the offered write |
| dr_addr | output | 32 | Line address, bits 3:0 zero |
| dr_data | output | 128 | Line data |
| dr_mask | output | 16 | Byte-valid mask of the line |

## Verification
A store taken at clock edge N from an idle buffer is offered combinationally in the following cycle, so its handshake falls at edge N+1. After each handshake the next one cannot come before edge N+5. The bench stamps every store acceptance and every drain handshake with the edge count, then compares the differences with these figures. The stamps are recorded in a monitor at the edge itself, while the stimulus is driven and `st_ready` and the drain port are read at falling edges. So each comparison uses values that settled a half period earlier.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  localparam int LINE_BYTES = 16;
  localparam int WORD_BYTES = 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WOFF_W     = $clog2(WORD_BYTES);
  localparam int SLOTS      = LINE_BYTES / WORD_BYTES;
  localparam int SLOT_W     = OFF_W - WOFF_W;

  typedef logic [LINE_BYTES*8-1:0] line_data_t;
  typedef logic [LINE_BYTES-1:0]   line_mask_t;
  typedef logic [WORD_BYTES*8-1:0] word_data_t;
  typedef logic [WORD_BYTES-1:0]   word_mask_t;
endpackage

// File: rtl/stbuf_entry.sv
module stbuf_entry
  import stbuf_pkg::*;
#(
  parameter int LINE_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic              clr_i,
  input  logic [LINE_W-1:0] line_i,
  input  line_data_t        data_i,
  input  line_mask_t        mask_i,
  output logic              vld_o,
  output logic [LINE_W-1:0] line_o,
  output line_data_t        data_o,
  output line_mask_t        mask_o
);

  logic              vld_q, vld_d;
  logic [LINE_W-1:0] line_q, line_d;
  line_data_t        data_q, data_d;
  line_mask_t        mask_q, mask_d;
  logic              upd_en;

  // next state: allocation loads, merge ORs the mask, both write enabled bytes
  always_comb begin
    vld_d  = vld_q;
    line_d = line_q;
    mask_d = mask_q;
    data_d = data_q;
    if (alloc_i) begin
      vld_d  = 1'b1;
      line_d = line_i;
      mask_d = mask_i;
    end
    if (merge_i) begin
      mask_d = mask_q | mask_i;
    end
    if (alloc_i || merge_i) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (mask_i[b]) data_d[b*8 +: 8] = data_i[b*8 +: 8];
      end
    end
    if (clr_i) vld_d = 1'b0;
  end

  assign upd_en = alloc_i | merge_i | clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (upd_en) begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i || merge_i) begin
      line_q <= line_d;
      mask_q <= mask_d;
      data_q <= data_d;
    end
  end

  assign vld_o  = vld_q;
  assign line_o = line_q;
  assign data_o = data_q;
  assign mask_o = mask_q;

  AST_MERGE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> vld_q); // R3

  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (mask_q != '0)); // R2

endmodule

// File: rtl/stbuf_match.sv
module stbuf_match #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 28,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                         en_i,
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0]             blocked_i,
  input  logic [DEPTH-1:0][LINE_W-1:0] lines_i,
  input  logic [LINE_W-1:0]            key_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o
);

  logic [DEPTH-1:0] cand;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign cand[i] = vld_i[i] & ~blocked_i[i] & (lines_i[i] == key_i);
  end

  always_comb begin
    hit_o = en_i & (|cand);
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/stbuf_pacer.sv
module stbuf_pacer #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic open_o
);

  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (fire_i)            cnt_d = CW'(GAP - 1);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = fire_i | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign open_o = (cnt_q == '0);

  if (GAP > 1) begin : g_chk
    AST_PACE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> !open_o); // R7
  end

endmodule

// File: rtl/stbuf_merge.sv
module stbuf_merge
  import stbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int GAP    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    merge_en,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [WORD_BYTES*8-1:0] st_data,
  input  logic [WORD_BYTES-1:0]   st_be,
  output logic                    dr_valid,
  input  logic                    dr_accept,
  output logic [ADDR_W-1:0]       dr_addr,
  output logic [LINE_BYTES*8-1:0] dr_data,
  output logic [LINE_BYTES-1:0]   dr_mask
);

  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int SW     = $clog2(GAP + 1);

  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ptr_en;

  logic [DEPTH-1:0]             ent_vld;
  logic [DEPTH-1:0][LINE_W-1:0] ent_line;
  line_data_t                   ent_data [DEPTH];
  line_mask_t                   ent_mask [DEPTH];

  logic [DEPTH-1:0] alloc_v, merge_v, clr_v, blocked;
  logic [LINE_W-1:0] key;
  logic [SLOT_W-1:0] slot;
  line_data_t        in_data;
  line_mask_t        in_mask;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              full, take, do_merge, do_alloc, fire, pace_open;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // place the 64-bit store into its half of the line
  assign key  = st_addr[ADDR_W-1:OFF_W];
  assign slot = st_addr[OFF_W-1:WOFF_W];

  always_comb begin
    in_data = '0;
    in_mask = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot == SLOT_W'(s)) begin
        in_data[s*WORD_BYTES*8 +: WORD_BYTES*8] = st_data;
        in_mask[s*WORD_BYTES +: WORD_BYTES]     = st_be;
      end
    end
  end

  // the head entry is frozen while it is offered downstream
  always_comb begin
    blocked = '0;
    if (dr_valid) blocked[head_q] = 1'b1;
  end

  stbuf_match #(
    .DEPTH  (DEPTH),
    .LINE_W (LINE_W),
    .IDX_W  (IDX_W)
  ) u_match (
    .en_i      (merge_en),
    .vld_i     (ent_vld),
    .blocked_i (blocked),
    .lines_i   (ent_line),
    .key_i     (key),
    .hit_o     (hit),
    .idx_o     (hit_idx)
  );

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign st_ready = hit | ~full;
  assign take     = st_valid & st_ready & (|st_be);
  assign do_merge = take & hit;
  assign do_alloc = take & ~hit;
  assign fire     = dr_valid & dr_accept;

  always_comb begin
    alloc_v = '0;
    merge_v = '0;
    clr_v   = '0;
    if (do_alloc) alloc_v[tail_q]  = 1'b1;
    if (do_merge) merge_v[hit_idx] = 1'b1;
    if (fire)     clr_v[head_q]    = 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    stbuf_entry #(
      .LINE_W (LINE_W)
    ) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_i (alloc_v[i]),
      .merge_i (merge_v[i]),
      .clr_i   (clr_v[i]),
      .line_i  (key),
      .data_i  (in_data),
      .mask_i  (in_mask),
      .vld_o   (ent_vld[i]),
      .line_o  (ent_line[i]),
      .data_o  (ent_data[i]),
      .mask_o  (ent_mask[i])
    );
  end

  // queue pointers and occupancy
  always_comb begin
    head_d = fire ? bump(head_q) : head_q;
    tail_d = do_alloc ? bump(tail_q) : tail_q;
    cnt_d  = cnt_q + CNT_W'(do_alloc) - CNT_W'(fire);
  end

  assign ptr_en = do_alloc | fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  stbuf_pacer #(
    .GAP (GAP)
  ) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .open_o (pace_open)
  );

  assign dr_valid = ent_vld[head_q] & pace_open;
  assign dr_addr  = {ent_line[head_q], {OFF_W{1'b0}}};
  assign dr_data  = ent_data[head_q];
  assign dr_mask  = ent_mask[head_q];

  // independent edge counter since the last drain handshake
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= SW'(GAP);
    end else if (fire) begin
      since_q <= SW'(1);
    end else if (since_q != SW'(GAP)) begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_STORE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_addr[WOFF_W-1:0] == '0)); // R2

  AST_DRAIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> (dr_mask != '0)); // R2

  AST_DRAIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (since_q == SW'(GAP))); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R8

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc |-> !ent_vld[tail_q]); // R8

  AST_HEAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> !(do_merge && (hit_idx == head_q))); // R9

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_accept) |=> (dr_valid && $stable(dr_addr)
      && $stable(dr_mask) && $stable(dr_data))); // R10

endmodule

// File: tb/stbuf_merge_tb.sv
module stbuf_merge_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         merge_en;
  logic         st_valid;
  logic         st_ready;
  logic [31:0]  st_addr;
  logic [63:0]  st_data;
  logic [7:0]   st_be;
  logic         dr_valid;
  logic         dr_accept;
  logic [31:0]  dr_addr;
  logic [127:0] dr_data;
  logic [15:0]  dr_mask;

  always #10 clk = ~clk;

  stbuf_merge u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .merge_en  (merge_en),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_addr   (st_addr),
    .st_data   (st_data),
    .st_be     (st_be),
    .dr_valid  (dr_valid),
    .dr_accept (dr_accept),
    .dr_addr   (dr_addr),
    .dr_data   (dr_data),
    .dr_mask   (dr_mask)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0]  lg_addr [32];
  logic [127:0] lg_data [32];
  logic [15:0]  lg_mask [32];
  int           lg_cyc  [32];
  int           lg_n = 0;

  always @(posedge clk) begin
    if (rst_n && dr_valid && dr_accept && lg_n < 32) begin
      lg_addr[lg_n] <= dr_addr;
      lg_data[lg_n] <= dr_data;
      lg_mask[lg_n] <= dr_mask;
      lg_cyc[lg_n]  <= cyc;
      lg_n          <= lg_n + 1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] bytes_of(input logic [15:0] m);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = {8{m[i]}};
    return r;
  endfunction

  task automatic push(input logic [31:0] a, input logic [63:0] d,
                      input logic [7:0] be, output int at);
    @(negedge clk);
    st_valid = 1'b1;
    st_addr  = a;
    st_data  = d;
    st_be    = be;
    #1;
    while (!st_ready) begin
      @(negedge clk);
      #1;
    end
    at = cyc;
    @(posedge clk);
    #1 st_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain_chk(input string req, input int i, input logic [31:0] a,
                           input logic [15:0] m, input logic [127:0] d);
    chk(req, "drain addr", {96'h0, lg_addr[i]}, {96'h0, a});
    chk(req, "drain mask", {112'h0, lg_mask[i]}, {112'h0, m});
    chk(req, "drain data", lg_data[i] & bytes_of(m), d & bytes_of(m));
  endtask

  task automatic probe(input logic [31:0] a, output logic r);
    @(negedge clk);
    st_valid = 1'b0;
    st_addr  = a;
    #1 r = st_ready;
  endtask

  task automatic t_reset();
    chk("R1", "dr_valid in reset", {127'h0, dr_valid}, 128'h0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1", "dr_valid after reset", {127'h0, dr_valid}, 128'h0);
    chk("R1", "st_ready after reset", {127'h0, st_ready}, 128'h1);
  endtask

  task automatic t_single();
    int base, a;
    base = lg_n;
    push(32'h0000_0108, 64'h1122_3344_5566_7788, 8'hFF, a);
    settle(8);
    chk("R2", "drain count", 128'(lg_n - base), 128'd1);
    drain_chk("R2", base, 32'h0000_0100, 16'hFF00, {64'h1122_3344_5566_7788, 64'h0});
    chk("R2", "drain edge", 128'(lg_cyc[base] - a), 128'd1);
  endtask

  task automatic t_merge();
    int base, a0, a1, a2;
    base = lg_n;
    push(32'h0000_1000, 64'hA0A0_A0A0_A0A0_A0A0, 8'hFF, a0);
    push(32'h0000_2000, 64'hB1B2_B3B4_B5B6_B7B8, 8'hFF, a1);
    push(32'h0000_2008, 64'hC1C2_C3C4_C5C6_C7C8, 8'hFF, a2);
    settle(12);
    chk("R3", "drain count", 128'(lg_n - base), 128'd2);
    drain_chk("R3", base, 32'h0000_1000, 16'h00FF, {64'h0, 64'hA0A0_A0A0_A0A0_A0A0});
    drain_chk("R3", base + 1, 32'h0000_2000, 16'hFFFF,
              {64'hC1C2_C3C4_C5C6_C7C8, 64'hB1B2_B3B4_B5B6_B7B8});
    chk("R2", "first drain edge", 128'(lg_cyc[base] - a0), 128'd1);
    chk("R7", "drain spacing", 128'(lg_cyc[base + 1] - lg_cyc[base]), 128'd4);
  endtask

  task automatic t_overlap();
    int base, a0, a1, a2;
    base = lg_n;
    push(32'h0000_1100, 64'h0101_0101_0101_0101, 8'hFF, a0);
    push(32'h0000_2100, 64'h1111_2222_3333_4444, 8'hFF, a1);
    push(32'h0000_2100, 64'h9999_8888_7777_6666, 8'h0F, a2);
    settle(12);
    chk("R4", "drain count", 128'(lg_n - base), 128'd2);
    drain_chk("R4", base + 1, 32'h0000_2100, 16'h00FF,
              {64'h0, 32'h1111_2222, 32'h7777_6666});
  endtask

  task automatic t_nomerge();
    int base, a0, a1, a2;
    @(negedge clk) merge_en = 1'b0;
    base = lg_n;
    push(32'h0000_1000, 64'hD0D0_D0D0_D0D0_D0D0, 8'hFF, a0);
    push(32'h0000_2000, 64'hE1E1_E1E1_E1E1_E1E1, 8'hFF, a1);
    push(32'h0000_2008, 64'hF2F2_F2F2_F2F2_F2F2, 8'hFF, a2);
    settle(16);
    chk("R5", "drain count", 128'(lg_n - base), 128'd3);
    drain_chk("R5", base + 1, 32'h0000_2000, 16'h00FF, {64'h0, 64'hE1E1_E1E1_E1E1_E1E1});
    drain_chk("R5", base + 2, 32'h0000_2000, 16'hFF00, {64'hF2F2_F2F2_F2F2_F2F2, 64'h0});
    chk("R7", "spacing 2-3", 128'(lg_cyc[base + 2] - lg_cyc[base + 1]), 128'd4);
    @(negedge clk) merge_en = 1'b1;
  endtask

  task automatic t_full();
    int base, a;
    logic r;
    base = lg_n;
    @(negedge clk) dr_accept = 1'b0;
    push(32'h0000_3000, 64'h3333_3333_3333_3333, 8'hFF, a);
    push(32'h0000_4000, 64'h4444_4444_4444_4444, 8'hFF, a);
    push(32'h0000_5000, 64'h5555_5555_5555_5555, 8'hFF, a);
    push(32'h0000_6000, 64'h6666_6666_6666_6666, 8'hFF, a);
    @(negedge clk);
    #1;
    chk("R10", "dr_valid held", {127'h0, dr_valid}, 128'h1);
    chk("R10", "held addr", {96'h0, dr_addr}, {96'h0, 32'h0000_3000});
    settle(3);
    #1;
    chk("R10", "addr stable", {96'h0, dr_addr}, {96'h0, 32'h0000_3000});
    chk("R10", "mask stable", {112'h0, dr_mask}, {112'h0, 16'h00FF});
    probe(32'h0000_7000, r);
    chk("R8", "ready full new line", {127'h0, r}, 128'h0);
    probe(32'h0000_3008, r);
    chk("R9", "ready full frozen head line", {127'h0, r}, 128'h0);
    probe(32'h0000_5008, r);
    chk("R8", "ready full merge target", {127'h0, r}, 128'h1);
    push(32'h0000_5008, 64'h5A5A_5A5A_5A5A_5A5A, 8'hFF, a);
    @(negedge clk) dr_accept = 1'b1;
    settle(20);
    chk("R6", "drain count", 128'(lg_n - base), 128'd4);
    chk("R6", "order 0", {96'h0, lg_addr[base]},     {96'h0, 32'h0000_3000});
    chk("R6", "order 1", {96'h0, lg_addr[base + 1]}, {96'h0, 32'h0000_4000});
    chk("R6", "order 3", {96'h0, lg_addr[base + 3]}, {96'h0, 32'h0000_6000});
    drain_chk("R3", base + 2, 32'h0000_5000, 16'hFFFF,
              {64'h5A5A_5A5A_5A5A_5A5A, 64'h5555_5555_5555_5555});
    chk("R7", "spacing full", 128'(lg_cyc[base + 3] - lg_cyc[base + 2]), 128'd4);
  endtask

  task automatic t_lock();
    int base, a;
    base = lg_n;
    @(negedge clk) dr_accept = 1'b0;
    push(32'h0000_8000, 64'h8080_8080_8080_8080, 8'hFF, a);
    settle(2);
    push(32'h0000_8008, 64'h8181_8181_8181_8181, 8'hFF, a);
    settle(1);
    @(negedge clk) dr_accept = 1'b1;
    settle(12);
    chk("R9", "drain count", 128'(lg_n - base), 128'd2);
    drain_chk("R9", base, 32'h0000_8000, 16'h00FF, {64'h0, 64'h8080_8080_8080_8080});
    drain_chk("R9", base + 1, 32'h0000_8000, 16'hFF00, {64'h8181_8181_8181_8181, 64'h0});
  endtask

  task automatic t_zero_be();
    int base, a;
    base = lg_n;
    push(32'h0000_9000, 64'hDEAD_BEEF_DEAD_BEEF, 8'h00, a);
    settle(10);
    #1;
    chk("R11", "drain count", 128'(lg_n - base), 128'd0);
    chk("R11", "dr_valid", {127'h0, dr_valid}, 128'h0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    merge_en  = 1'b1;
    st_valid  = 1'b0;
    st_addr   = '0;
    st_data   = '0;
    st_be     = '0;
    dr_accept = 1'b1;
    settle(3);
    t_reset();
    settle(4);
    t_single();
    t_merge();
    t_overlap();
    t_nomerge();
    t_full();
    t_lock();
    t_zero_be();
    finish_run();
  end

endmodule